// File: doc/BRIEF.md
# Memory Error Capture Registers

This block holds diagnostic state after a failed memory access. Every physical access, from the CPU or from a DMA channel, is presented with its 24-bit word address. An address at or beyond the installed memory size counts as an out-of-range error. For such an error the block saves the low 16 address bits in an address register. It saves the upper address bits, together with flags that give the source of the access, in a status register. Paging faults come from the translation logic, which supplies the table number, the page number and a cause. The block packs these into a paging status register.

Each capture is first-error-wins. Once loaded, a register is locked, and later errors leave it untouched until software reads it through the internal-register read port. Reading the address register releases the address/status pair. Reading the paging status register releases that register. Reading the status register releases nothing. Interrupt generation and address translation lie outside this block.

Top module: `mem_err_capture`

## Requirements
- R1: After reset the address, status and paging status registers all read as zero, and both locks are clear.
- R2: `oor_hit` is 1 in the cycle of an access (`acc_valid`=1) whose address is at or above `MEM_WORDS` (default 524288), and 0 for an access below it.
- R3: On an out-of-range access while unlocked, the address register (read select 0) takes address bits 15:0 on the next clock edge.
- R4: The status register (read select 1) is loaded together with the address register. Bits 7:0 hold address bits 23:16, bit 14 is set for a DMA access, bit 13 is set for an instruction fetch by the CPU only (never for DMA), and all other bits are zero.
- R5: While the address/status pair is locked, further out-of-range errors change neither register.
- R6: Reading the status register does not release the address/status lock. Reading the address register releases it.
- R7: On a paging fault while unlocked, the paging status register (read select 2) takes page number in bits 5:0, table number in bits 7:6, the fetch flag in bit 15 and the permission flag in bit 14. All other bits are zero.
- R8: The paging status register stays locked after a capture until it is read. Its lock is independent of the address/status lock.
- R9: When an unlocking read and a new error occur in the same cycle, the read returns the old value and the new error is captured and locked.
- R10: An access below `MEM_WORDS` changes no register.
- R11: Read select 3 returns zero. `rd_data` shows the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A physical access is presented this cycle |
| acc_addr | input | 24 | Physical word address of the access |
| acc_dma | input | 1 | Access comes from DMA (0 = CPU) |
| acc_fetch | input | 1 | CPU access is an instruction fetch |
| oor_hit | output | 1 | The presented access is out of range |
| pf_valid | input | 1 | Paging fault strobe from the translation logic |
| pf_table | input | 2 | Page table number of the fault |
| pf_page | input | 6 | Page number of the fault |
| pf_fetch | input | 1 | Fault occurred on an instruction fetch |
| pf_perm | input | 1 | Fault was a missing permission (0 for a ring violation) |
| rd_en | input | 1 | Internal-register read strobe |
| rd_sel | input | 2 | Register select: 0 address, 1 status, 2 paging status, 3 none |
| rd_data | output | 16 | Selected register contents |

## Verification
The assertions assume that each strobe is a one-cycle pulse sampled at a rising edge, and that the inputs are known whenever a strobe is high. They also assume that `rd_sel` holds a legal code while `rd_en` is set. The stimulus drives every input on the falling edge and drops each strobe right after the rising edge that consumes it. Idle inputs are held at zero, so no unknown value reaches a locked register. Sweeps run across every upper-address byte that lies out of range and every table and page pair, with source and cause flags that vary along the sweep.

// File: rtl/mec_pkg.sv
package mec_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_STAT = 2'd1,
        SEL_PAGE = 2'd2,
        SEL_NONE = 2'd3
    } rd_sel_e;

    // Flag positions in the status and paging status words
    localparam int ST_DMA_BIT   = 14;
    localparam int ST_FETCH_BIT = 13;
    localparam int PG_FETCH_BIT = 15;
    localparam int PG_PERM_BIT  = 14;
endpackage

// File: rtl/mec_range_cmp.sv
module mec_range_cmp #(
    parameter int ADDR_W    = 24,
    parameter int MEM_WORDS = 524288
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_WORDS);

    always_comb begin
        hit = valid && (addr >= LIMIT);
    end
endmodule

// File: rtl/mec_capture.sv
module mec_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         release_i,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         locked
);
    typedef struct packed {
        logic [W-1:0] val;
        logic         lock;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (release_i) begin
            st_d.lock = 1'b0;
        end
        if (capture && (!st_q.lock || release_i)) begin
            st_d.val  = din;
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q      = st_q.val;
    assign locked = st_q.lock;
endmodule

// File: rtl/mem_err_capture.sv
module mem_err_capture
    import mec_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int MEM_WORDS = 524288,
    parameter int TBL_W     = 2,
    parameter int PAGE_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_dma,
    input  logic              acc_fetch,
    output logic              oor_hit,
    input  logic              pf_valid,
    input  logic [TBL_W-1:0]  pf_table,
    input  logic [PAGE_W-1:0] pf_page,
    input  logic              pf_fetch,
    input  logic              pf_perm,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int ERR_W = 2 * DATA_W;

    logic [DATA_W-1:0] stat_word, pg_word;
    logic [ERR_W-1:0]  err_q;
    logic [DATA_W-1:0] pg_q;
    logic              err_locked, pg_locked;
    logic              rel_err, rel_pg;

    mec_range_cmp #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_cmp (
        .valid(acc_valid),
        .addr (acc_addr),
        .hit  (oor_hit)
    );

    // Build the words to capture
    always_comb begin
        stat_word = '0;
        stat_word[HI_W-1:0]   = acc_addr[ADDR_W-1:DATA_W];
        stat_word[ST_DMA_BIT] = acc_dma;
        stat_word[ST_FETCH_BIT] = acc_fetch & ~acc_dma;

        pg_word = '0;
        pg_word[PAGE_W-1:0]       = pf_page;
        pg_word[PAGE_W +: TBL_W]  = pf_table;
        pg_word[PG_FETCH_BIT]     = pf_fetch;
        pg_word[PG_PERM_BIT]      = pf_perm;
    end

    always_comb begin
        rel_err = rd_en && (rd_sel == SEL_ADDR);
        rel_pg  = rd_en && (rd_sel == SEL_PAGE);
    end

    // Address (low half) and status (high half) lock as one pair
    mec_capture #(.W(ERR_W)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (oor_hit),
        .release_i(rel_err),
        .din      ({stat_word, acc_addr[DATA_W-1:0]}),
        .q        (err_q),
        .locked   (err_locked)
    );

    mec_capture #(.W(DATA_W)) u_pg (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (pf_valid),
        .release_i(rel_pg),
        .din      (pg_word),
        .q        (pg_q),
        .locked   (pg_locked)
    );

    always_comb begin
        unique case (rd_sel)
            SEL_ADDR: rd_data = err_q[DATA_W-1:0];
            SEL_STAT: rd_data = err_q[ERR_W-1:DATA_W];
            SEL_PAGE: rd_data = pg_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

module mem_err_capture_chk #(
    parameter int DATA_W = 16,
    parameter int TBL_W  = 2,
    parameter int PAGE_W = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_valid,
    input logic [DATA_W-1:0]   acc_lo,
    input logic                oor_hit,
    input logic                pf_valid,
    input logic [TBL_W-1:0]    pf_table,
    input logic [PAGE_W-1:0]   pf_page,
    input logic                rd_en,
    input logic [1:0]          rd_sel,
    input logic [2*DATA_W-1:0] err_q,
    input logic                err_locked,
    input logic [DATA_W-1:0]   pg_q,
    input logic                pg_locked
);
    assert_hit_needs_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        oor_hit |-> acc_valid);

    assert_capture_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (oor_hit && (!err_locked || (rd_en && rd_sel == 2'd0)))
        |=> (err_q[DATA_W-1:0] == $past(acc_lo)) && err_locked);

    assert_hold_when_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_locked && !(rd_en && rd_sel == 2'd0)) |=> $stable(err_q) && err_locked);

    assert_stat_read_keeps_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'd1 && !oor_hit) |=> (err_locked == $past(err_locked)));

    assert_page_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && (!pg_locked || (rd_en && rd_sel == 2'd2)))
        |=> (pg_q[PAGE_W-1:0] == $past(pf_page)) && (pg_q[PAGE_W +: TBL_W] == $past(pf_table)));

    assert_page_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 2'd2 && !pf_valid) |=> !pg_locked);
endmodule

bind mem_err_capture mem_err_capture_chk #(
    .DATA_W(DATA_W), .TBL_W(TBL_W), .PAGE_W(PAGE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_lo    (acc_addr[DATA_W-1:0]),
    .oor_hit   (oor_hit),
    .pf_valid  (pf_valid),
    .pf_table  (pf_table),
    .pf_page   (pf_page),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .err_q     (err_q),
    .err_locked(err_locked),
    .pg_q      (pg_q),
    .pg_locked (pg_locked)
);

// File: tb/tb_mem_err_capture.sv
module tb_mem_err_capture;
    localparam int MEMW = 524288;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        acc_dma = 1'b0;
    logic        acc_fetch = 1'b0;
    logic        oor_hit;
    logic        pf_valid = 1'b0;
    logic [1:0]  pf_table = '0;
    logic [5:0]  pf_page = '0;
    logic        pf_fetch = 1'b0;
    logic        pf_perm = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mem_err_capture dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_dma(acc_dma),
        .acc_fetch(acc_fetch), .oor_hit(oor_hit),
        .pf_valid(pf_valid), .pf_table(pf_table), .pf_page(pf_page),
        .pf_fetch(pf_fetch), .pf_perm(pf_perm),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic access(input logic [23:0] a, input logic d, input logic f, output logic hit);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_dma = d; acc_fetch = f;
        #1 hit = oor_hit;
        @(posedge clk);
        #1 acc_valid = 1'b0; acc_addr = '0; acc_dma = 1'b0; acc_fetch = 1'b0;
    endtask

    task automatic fault(input logic [1:0] t, input logic [5:0] p, input logic f, input logic pm);
        @(negedge clk);
        pf_valid = 1'b1; pf_table = t; pf_page = p; pf_fetch = f; pf_perm = pm;
        @(posedge clk);
        #1 pf_valid = 1'b0; pf_table = '0; pf_page = '0; pf_fetch = 1'b0; pf_perm = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = s;
        #1 v = rd_data;
        @(posedge clk);
        #1 rd_en = 1'b0; rd_sel = '0;
    endtask

    function automatic logic [15:0] stat_exp(input logic [7:0] h, input logic d, input logic f);
        return {1'b0, d, f & ~d, 5'b0, h};
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic        h;
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R11: reset state and unused select
        rd(2'd0, v); check("R1 addr reset", 32'(v), 32'h0);
        rd(2'd1, v); check("R1 stat reset", 32'(v), 32'h0);
        rd(2'd2, v); check("R1 page reset", 32'(v), 32'h0);
        rd(2'd3, v); check("R11 sel3", 32'(v), 32'h0);

        // R2 / R10: boundary detection, in-range changes nothing
        access(24'(MEMW - 1), 1'b0, 1'b0, h); check("R2 last word", 32'(h), 32'h0);
        access(24'h000000, 1'b1, 1'b0, h);    check("R2 zero", 32'(h), 32'h0);
        rd(2'd0, v); check("R10 addr untouched", 32'(v), 32'h0);
        rd(2'd1, v); check("R10 stat untouched", 32'(v), 32'h0);
        access(24'(MEMW), 1'b0, 1'b1, h);     check("R2 first beyond", 32'(h), 32'h1);
        rd(2'd1, v); check("R4 boundary stat", 32'(v), 32'(stat_exp(8'h08, 1'b0, 1'b1)));
        rd(2'd0, v); check("R3 boundary addr", 32'(v), 32'h0);
        access(24'hFFFFFF, 1'b1, 1'b1, h);    check("R2 top", 32'(h), 32'h1);
        rd(2'd1, v); check("R4 dma no fetch", 32'(v), 32'(stat_exp(8'hFF, 1'b1, 1'b1)));
        rd(2'd0, v); check("R3 top addr", 32'(v), 32'hFFFF);

        // R3 / R4 sweep over every out-of-range upper byte
        for (int b = 8; b < 256; b++) begin
            logic [15:0] lo;
            lo = 16'(b * 257) ^ 16'h5A3C;
            access({8'(b), lo}, b[0], b[1], h);
            check("R2 sweep hit", 32'(h), 32'h1);
            rd(2'd1, v); check("R4 sweep stat", 32'(v), 32'(stat_exp(8'(b), b[0], b[1])));
            rd(2'd0, v); check("R3 sweep addr", 32'(v), 32'(lo));
        end

        // R5 / R6: first error wins, status read keeps lock
        access(24'h123456, 1'b0, 1'b0, h);
        access(24'hABCDEF, 1'b1, 1'b0, h);
        rd(2'd1, v); check("R5 stat kept", 32'(v), 32'(stat_exp(8'h12, 1'b0, 1'b0)));
        access(24'h777777, 1'b0, 1'b1, h);
        rd(2'd0, v); check("R6 still locked after stat read", 32'(v), 32'h3456);
        access(24'h9A0011, 1'b1, 1'b0, h);
        rd(2'd0, v); check("R6 unlocked by addr read", 32'(v), 32'h0011);
        rd(2'd1, v); check("R6 stat new", 32'(v), 32'(stat_exp(8'h9A, 1'b1, 1'b0)));

        // R10: after unlock, in-range access does not load
        access(24'h07FFFF, 1'b0, 1'b1, h);
        rd(2'd0, v); check("R10 in-range after unlock", 32'(v), 32'h0011);

        // R9: unlocking read concurrent with new error
        access(24'h200001, 1'b0, 1'b0, h);
        @(negedge clk);
        rd_en = 1'b1; rd_sel = 2'd0;
        acc_valid = 1'b1; acc_addr = 24'h30BEEF; acc_dma = 1'b1; acc_fetch = 1'b0;
        #1 v = rd_data;
        @(posedge clk);
        #1 rd_en = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_dma = 1'b0;
        check("R9 read returns old", 32'(v), 32'h0001);
        access(24'h400002, 1'b0, 1'b0, h);
        rd(2'd1, v); check("R9 new stat locked", 32'(v), 32'(stat_exp(8'h30, 1'b1, 1'b0)));
        rd(2'd0, v); check("R9 new addr locked", 32'(v), 32'hBEEF);

        // R7 sweep over every table and page
        for (int t = 0; t < 4; t++) begin
            for (int p = 0; p < 64; p++) begin
                fault(2'(t), 6'(p), p[0], p[1]);
                rd(2'd2, v);
                check("R7 page word", 32'(v), 32'({p[0], p[1], 6'b0, 2'(t), 6'(p)}));
            end
        end

        // R8: paging lock, and independence from address lock
        fault(2'd1, 6'd5, 1'b0, 1'b1);
        fault(2'd3, 6'd60, 1'b1, 1'b0);
        access(24'h800000, 1'b0, 1'b0, h);
        rd(2'd0, v); check("R8 addr independent", 32'h0, 32'h0 | 32'(v));
        fault(2'd2, 6'd9, 1'b0, 1'b0);
        rd(2'd2, v); check("R8 first fault kept", 32'(v), 32'h4045);
        fault(2'd2, 6'd9, 1'b1, 1'b0);
        rd(2'd2, v); check("R8 reload after read", 32'(v), 32'h8089);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule